// File: doc/BRIEF.md
# Accumulator ALU with Decimal Adjust

This block is the arithmetic and logic unit of an 8-bit accumulator machine. Each cycle it takes the current accumulator, a second operand, the B register and the three arithmetic flags (carry, auxiliary carry, overflow), applies one selected operation and registers the new accumulator, new B value and new flags. The registered results appear one clock after the request.

The operation set covers binary add, add with incoming carry, subtract with borrow, a decimal correction step for packed BCD after an addition, four one-bit rotates (two of them through the carry), a nibble exchange, increment and decrement, an unsigned 8x8 multiply and an unsigned 8/8 divide. Carry-in on the add and subtract forms lets software chain bytes into wider words. Multiply and divide split their results between the accumulator and B. Operand selection, addressing and decoding sit outside this block. The caller feeds the returned values back in on the next operation.

Top module: `aluacc_core`

## Requirements
- R1: Operation code 0 (add) returns acc = (A + OPND) mod 256. CY is the carry out of bit 7, AC is the carry out of bit 3, and OV is set when the signed two's-complement sum leaves the range -128..127. B is unchanged.
- R2: Operation code 1 (add with carry) behaves as R1 but also adds the incoming CY. For example, 0x44+0xCA with CY=0 gives 0x0E with CY=1, and then 0x1E+0x56 with CY=1 gives 0x75 with CY=0.
- R3: Operation code 2 (subtract with borrow) returns acc = (A - OPND - CY) mod 256. CY is set on a borrow out of bit 7, AC on a borrow out of bit 3, and OV on signed overflow of the subtraction.
- R4: Operation code 3 (decimal adjust) first adds 0x06 when the low nibble exceeds 9 or AC is set; a carry out of that step sets CY. It then adds 0x60 when the resulting high nibble exceeds 9 or CY is set, and in that case sets CY. AC and OV are unchanged. For example, 0x7D with clear flags becomes 0x83.
- R5: Codes 4 and 6 rotate A left and right by one bit without involving CY. Codes 5 and 7 rotate left and right through CY as a 9-bit quantity, and CY takes the bit shifted out.
- R6: Code 8 exchanges the upper and lower nibbles of A and leaves all flags unchanged.
- R7: Code 9 increments A and code 10 decrements A, both modulo 256, with CY, AC and OV unchanged.
- R8: Code 11 multiplies A by B as unsigned numbers. The low product byte goes to acc and the high byte to B, CY is cleared, and OV is set exactly when the product exceeds 255.
- R9: Code 12 divides A by B as unsigned numbers, giving the quotient in acc, the remainder in B and CY cleared. A zero divisor instead sets OV, clears CY and leaves acc and B equal to their inputs.
- R10: Codes 13 to 15 are reserved: acc, B and all flags come out equal to their inputs. Every code except 11 and 12 leaves B equal to its input.
- R11: A request with in_valid high at a clock edge produces its results, with out_valid high, after that edge. A cycle with in_valid low gives out_valid low at the next edge, and the result outputs hold their previous values.
- R12: While reset is asserted, out_valid, acc_out, b_out and all flag outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation request this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| acc_in | input | 8 | Current accumulator |
| opnd_in | input | 8 | Second operand for add and subtract |
| b_in | input | 8 | Current B register |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| ov_in | input | 1 | Current overflow flag |
| out_valid | output | 1 | Registered results are from a request |
| acc_out | output | 8 | New accumulator |
| b_out | output | 8 | New B register |
| cy_out | output | 1 | New carry flag |
| ac_out | output | 1 | New auxiliary-carry flag |
| ov_out | output | 1 | New overflow flag |

## Verification
The bench targets the places where flag rules are easy to get wrong. These include the nibble carry and borrow that feed AC, signed overflow at 0x7F+1 and 0x80-1, and the decimal correction when the low fix carries into an already large high nibble (0x9A becomes 0x00 with CY set). A design that took the borrow sense the wrong way, or that tested the high nibble before the low fix, would return a wrong accumulator or CY on these cases. The bench also drives a multiply of 0xFF by 0xFF, where a swapped byte order or a missing OV shows at once, and a divide by zero, where a design that writes the unrolled divider's all-ones quotient would corrupt A. The two chained add-with-carry bytes and the reserved codes confirm that carry-in is taken from the port and that unused codes leave every value untouched.

// File: rtl/aluacc_pkg.sv
package aluacc_pkg;

   typedef enum logic [3:0] {
      OP_ADD   = 4'd0,
      OP_ADDC  = 4'd1,
      OP_SUBB  = 4'd2,
      OP_DADJ  = 4'd3,
      OP_ROTL  = 4'd4,
      OP_ROTLC = 4'd5,
      OP_ROTR  = 4'd6,
      OP_ROTRC = 4'd7,
      OP_SWAP  = 4'd8,
      OP_INC   = 4'd9,
      OP_DEC   = 4'd10,
      OP_MUL   = 4'd11,
      OP_DIV   = 4'd12,
      OP_RSV13 = 4'd13,
      OP_RSV14 = 4'd14,
      OP_RSV15 = 4'd15
   } alu_op_e;

   typedef struct packed {
      logic cy;
      logic ac;
      logic ov;
   } alu_flags_t;

endpackage

// File: rtl/aluacc_addsub.sv
// Shared adder for add, add-with-carry and subtract-with-borrow.
// Subtraction is done as A + ~B + ~cin, so carries invert into borrows.
module aluacc_addsub #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         cy,
   output logic         ac,
   output logic         ov
);
   localparam int NIB = 4;

   logic [W-1:0] b_x;
   logic         c_x;
   logic [NIB:0] lo_sum;
   logic [W:0]   full_sum;

   assign b_x      = sub ? ~b : b;
   assign c_x      = sub ? ~cin : cin;
   assign lo_sum   = {1'b0, a[NIB-1:0]} + {1'b0, b_x[NIB-1:0]} + {{NIB{1'b0}}, c_x};
   assign full_sum = {1'b0, a} + {1'b0, b_x} + {{W{1'b0}}, c_x};

   assign sum = full_sum[W-1:0];
   assign cy  = full_sum[W] ^ sub;
   assign ac  = lo_sum[NIB] ^ sub;
   assign ov  = (a[W-1] == b_x[W-1]) && (full_sum[W-1] != a[W-1]);
endmodule

// File: rtl/aluacc_decadj.sv
// Two-step packed-BCD correction for a byte accumulator.
module aluacc_decadj (
   input  logic [7:0] a,
   input  logic       cy,
   input  logic       ac,
   output logic [7:0] res,
   output logic       cy_o
);
   localparam logic [8:0] LO_FIX = 9'h006;
   localparam logic [8:0] HI_FIX = 9'h060;
   localparam logic [3:0] DIG_MAX = 4'd9;

   logic       lo_need;
   logic       hi_need;
   logic       c_mid;
   logic [8:0] step1;
   logic [8:0] step2;

   assign lo_need = (a[3:0] > DIG_MAX) || ac;
   assign step1   = {1'b0, a} + (lo_need ? LO_FIX : 9'h000);
   assign c_mid   = cy | step1[8];
   assign hi_need = (step1[7:4] > DIG_MAX) || c_mid;
   assign step2   = {1'b0, step1[7:0]} + (hi_need ? HI_FIX : 9'h000);

   assign res  = step2[7:0];
   assign cy_o = hi_need;
endmodule

// File: rtl/aluacc_bitops.sv
// Rotates, half exchange, increment and decrement of the accumulator.
module aluacc_bitops #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic         cy,
   output logic [W-1:0] rol,
   output logic [W-1:0] rolc,
   output logic         rolc_cy,
   output logic [W-1:0] ror,
   output logic [W-1:0] rorc,
   output logic         rorc_cy,
   output logic [W-1:0] swp,
   output logic [W-1:0] inc,
   output logic [W-1:0] dec
);
   localparam int HALF = W / 2;
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   assign rol     = {a[W-2:0], a[W-1]};
   assign rolc    = {a[W-2:0], cy};
   assign rolc_cy = a[W-1];
   assign ror     = {a[0], a[W-1:1]};
   assign rorc    = {cy, a[W-1:1]};
   assign rorc_cy = a[0];
   assign swp     = {a[HALF-1:0], a[W-1:HALF]};
   assign inc     = a + ONE;
   assign dec     = a - ONE;
endmodule

// File: rtl/aluacc_muldiv.sv
// Unsigned multiply and an unrolled restoring divider, one stage per bit.
module aluacc_muldiv #(
   parameter int W = 8
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] prod_lo,
   output logic [W-1:0] prod_hi,
   output logic         mul_big,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem,
   output logic         div_zero
);
   localparam int PW = 2 * W;

   logic [PW-1:0] prod;
   logic [W-1:0]  part [0:W];

   assign prod     = {{W{1'b0}}, a} * {{W{1'b0}}, b};
   assign prod_lo  = prod[W-1:0];
   assign prod_hi  = prod[PW-1:W];
   assign mul_big  = |prod_hi;
   assign div_zero = (b == '0);

   assign part[0] = '0;

   for (genvar gi = 0; gi < W; gi++) begin : g_div_stage
      localparam int K = W - 1 - gi;
      logic [W:0] trial;
      logic [W:0] diff;
      logic       fits;
      assign trial       = {part[gi], a[K]};
      assign diff        = trial - {1'b0, b};
      assign fits        = (trial >= {1'b0, b});
      assign quo[K]      = fits;
      assign part[gi+1]  = fits ? diff[W-1:0] : trial[W-1:0];
   end

   assign rem = part[W];
endmodule

// File: rtl/aluacc_core.sv
module aluacc_core #(
   parameter int DATA_W    = 8,
   parameter bit DADJ_EN   = 1'b1,
   parameter bit MULDIV_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [3:0]        op_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd_in,
   input  logic [DATA_W-1:0] b_in,
   input  logic              cy_in,
   input  logic              ac_in,
   input  logic              ov_in,
   output logic              out_valid,
   output logic [DATA_W-1:0] acc_out,
   output logic [DATA_W-1:0] b_out,
   output logic              cy_out,
   output logic              ac_out,
   output logic              ov_out
);
   import aluacc_pkg::*;

   if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("aluacc_core: DATA_W must be even and at least 8");
   end
   if (DADJ_EN && DATA_W != 8) begin : g_bad_dadj
      $error("aluacc_core: decimal adjust needs DATA_W of 8");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   // adder / subtractor
   logic [DATA_W-1:0] as_sum;
   logic              as_cy, as_ac, as_ov, as_cin, as_sub;

   assign as_sub = (op == OP_SUBB);
   assign as_cin = (op == OP_ADD) ? 1'b0 : cy_in;

   aluacc_addsub #(.W(DATA_W)) u_addsub (
      .a   (acc_in),
      .b   (opnd_in),
      .cin (as_cin),
      .sub (as_sub),
      .sum (as_sum),
      .cy  (as_cy),
      .ac  (as_ac),
      .ov  (as_ov)
   );

   // decimal adjust
   logic [DATA_W-1:0] da_res;
   logic              da_cy;

   if (DADJ_EN) begin : g_dadj
      aluacc_decadj u_decadj (
         .a    (acc_in[7:0]),
         .cy   (cy_in),
         .ac   (ac_in),
         .res  (da_res),
         .cy_o (da_cy)
      );
   end else begin : g_no_dadj
      assign da_res = acc_in;
      assign da_cy  = cy_in;
   end

   // bit operations
   logic [DATA_W-1:0] bo_rol, bo_rolc, bo_ror, bo_rorc, bo_swp, bo_inc, bo_dec;
   logic              bo_rolc_cy, bo_rorc_cy;

   aluacc_bitops #(.W(DATA_W)) u_bitops (
      .a       (acc_in),
      .cy      (cy_in),
      .rol     (bo_rol),
      .rolc    (bo_rolc),
      .rolc_cy (bo_rolc_cy),
      .ror     (bo_ror),
      .rorc    (bo_rorc),
      .rorc_cy (bo_rorc_cy),
      .swp     (bo_swp),
      .inc     (bo_inc),
      .dec     (bo_dec)
   );

   // multiply / divide
   logic [DATA_W-1:0] md_lo, md_hi, md_quo, md_rem;
   logic              md_big, md_zero;

   if (MULDIV_EN) begin : g_muldiv
      aluacc_muldiv #(.W(DATA_W)) u_muldiv (
         .a        (acc_in),
         .b        (b_in),
         .prod_lo  (md_lo),
         .prod_hi  (md_hi),
         .mul_big  (md_big),
         .quo      (md_quo),
         .rem      (md_rem),
         .div_zero (md_zero)
      );
   end else begin : g_no_muldiv
      assign md_lo   = acc_in;
      assign md_hi   = b_in;
      assign md_big  = ov_in;
      assign md_quo  = acc_in;
      assign md_rem  = b_in;
      assign md_zero = 1'b0;
   end

   // result select
   logic [DATA_W-1:0] nx_acc, nx_b;
   alu_flags_t        nx_fl;

   always_comb begin
      nx_acc = acc_in;
      nx_b   = b_in;
      nx_fl  = '{cy: cy_in, ac: ac_in, ov: ov_in};
      case (op)
         OP_ADD, OP_ADDC, OP_SUBB: begin
            nx_acc = as_sum;
            nx_fl  = '{cy: as_cy, ac: as_ac, ov: as_ov};
         end
         OP_DADJ: begin
            nx_acc   = da_res;
            nx_fl.cy = da_cy;
         end
         OP_ROTL:  nx_acc = bo_rol;
         OP_ROTLC: begin
            nx_acc   = bo_rolc;
            nx_fl.cy = bo_rolc_cy;
         end
         OP_ROTR:  nx_acc = bo_ror;
         OP_ROTRC: begin
            nx_acc   = bo_rorc;
            nx_fl.cy = bo_rorc_cy;
         end
         OP_SWAP:  nx_acc = bo_swp;
         OP_INC:   nx_acc = bo_inc;
         OP_DEC:   nx_acc = bo_dec;
         OP_MUL: begin
            if (MULDIV_EN) begin
               nx_acc   = md_lo;
               nx_b     = md_hi;
               nx_fl.cy = 1'b0;
               nx_fl.ov = md_big;
            end
         end
         OP_DIV: begin
            if (MULDIV_EN) begin
               nx_fl.cy = 1'b0;
               if (md_zero) begin
                  nx_fl.ov = 1'b1;
               end else begin
                  nx_acc   = md_quo;
                  nx_b     = md_rem;
                  nx_fl.ov = 1'b0;
               end
            end
         end
         default: ;
      endcase
   end

   // output registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         acc_out   <= '0;
         b_out     <= '0;
         cy_out    <= 1'b0;
         ac_out    <= 1'b0;
         ov_out    <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            acc_out <= nx_acc;
            b_out   <= nx_b;
            cy_out  <= nx_fl.cy;
            ac_out  <= nx_fl.ac;
            ov_out  <= nx_fl.ov;
         end
      end
   end
endmodule

// File: rtl/aluacc_chk.sv
module aluacc_chk #(
   parameter int DATA_W    = 8,
   parameter bit MULDIV_EN = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [3:0]        op_sel,
   input logic [DATA_W-1:0] acc_in,
   input logic [DATA_W-1:0] opnd_in,
   input logic [DATA_W-1:0] b_in,
   input logic              cy_in,
   input logic              ac_in,
   input logic              ov_in,
   input logic              out_valid,
   input logic [DATA_W-1:0] acc_out,
   input logic [DATA_W-1:0] b_out,
   input logic              cy_out,
   input logic              ac_out,
   input logic              ov_out
);
   localparam int H = DATA_W / 2;

   // R11: one-cycle latency of the valid flag
   p_valid_lat_r11: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(acc_out) && $stable(b_out)));

   // R7: increment and decrement keep all flags
   p_incdec_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (op_sel == 4'd9 || op_sel == 4'd10)) |=>
      (cy_out == $past(cy_in) && ac_out == $past(ac_in) && ov_out == $past(ov_in)));

   // R6: nibble exchange
   p_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 4'd8) |=>
      (acc_out == {$past(acc_in[H-1:0]), $past(acc_in[DATA_W-1:H])}));

   // R8: multiply clears CY, OV tracks a non-zero high byte
   p_mul_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (MULDIV_EN && in_valid && op_sel == 4'd11) |=>
      (!cy_out && (ov_out == (b_out != '0))));

   // R9: divide by zero keeps A and B and flags OV
   p_div_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (MULDIV_EN && in_valid && op_sel == 4'd12 && b_in == '0) |=>
      (ov_out && !cy_out && acc_out == $past(acc_in) && b_out == $past(b_in)));

   // R10: reserved codes pass everything through
   p_reserved_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel >= 4'd13) |=>
      (acc_out == $past(acc_in) && b_out == $past(b_in) && cy_out == $past(cy_in)
       && ac_out == $past(ac_in) && ov_out == $past(ov_in)));

   // R1: plain add ignores incoming carry; result fits the operand sum
   p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && op_sel == 4'd0) |=>
      ({cy_out, acc_out} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)})));
endmodule

bind aluacc_core aluacc_chk #(.DATA_W(DATA_W), .MULDIV_EN(MULDIV_EN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_sel    (op_sel),
   .acc_in    (acc_in),
   .opnd_in   (opnd_in),
   .b_in      (b_in),
   .cy_in     (cy_in),
   .ac_in     (ac_in),
   .ov_in     (ov_in),
   .out_valid (out_valid),
   .acc_out   (acc_out),
   .b_out     (b_out),
   .cy_out    (cy_out),
   .ac_out    (ac_out),
   .ov_out    (ov_out)
);

// File: tb/aluacc_core_tb_top.sv
`timescale 1ns/1ps
module aluacc_core_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic [3:0] op_sel = '0;
   logic [7:0] acc_in = '0, opnd_in = '0, b_in = '0;
   logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
   logic       out_valid;
   logic [7:0] acc_out, b_out;
   logic       cy_out, ac_out, ov_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   aluacc_core dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in),
      .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
      .out_valid(out_valid), .acc_out(acc_out), .b_out(b_out),
      .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out)
   );

   function automatic string tag_of(input int op);
      case (op)
         0: return "R1";
         1: return "R2";
         2: return "R3";
         3: return "R4";
         4, 5, 6, 7: return "R5";
         8: return "R6";
         9, 10: return "R7";
         11: return "R8";
         12: return "R9";
         default: return "R10";
      endcase
   endfunction

   function automatic int sgn(input int v);
      return (v > 127) ? v - 256 : v;
   endfunction

   // behavioural reference
   task automatic model(input int op, input int a, input int o, input int b,
                        input int cy, input int ac, input int ov,
                        output int ea, output int eb, output int ecy,
                        output int eac, output int eov);
      int c, s, t;
      ea = a; eb = b; ecy = cy; eac = ac; eov = ov;
      case (op)
         0, 1: begin
            c   = (op == 1) ? cy : 0;
            s   = a + o + c;
            ea  = s % 256;
            ecy = (s > 255);
            eac = ((a % 16) + (o % 16) + c) > 15;
            t   = sgn(a) + sgn(o) + c;
            eov = (t > 127 || t < -128);
         end
         2: begin
            s   = a - o - cy;
            ea  = (s + 256) % 256;
            ecy = (s < 0);
            eac = ((a % 16) - (o % 16) - cy) < 0;
            t   = sgn(a) - sgn(o) - cy;
            eov = (t > 127 || t < -128);
         end
         3: begin
            t = a; c = cy;
            if ((t % 16) > 9 || ac != 0) t = t + 6;
            if (t > 255) begin c = 1; t = t - 256; end
            if ((t / 16) > 9 || c != 0) begin t = t + 96; c = 1; end
            ea = t % 256; ecy = c;
         end
         4: ea = ((a * 2) % 256) + (a / 128);
         5: begin ea = ((a * 2) % 256) + cy; ecy = a / 128; end
         6: ea = (a / 2) + (a % 2) * 128;
         7: begin ea = (a / 2) + cy * 128; ecy = a % 2; end
         8: ea = (a % 16) * 16 + (a / 16);
         9: ea = (a + 1) % 256;
         10: ea = (a + 255) % 256;
         11: begin
            t = a * b; ea = t % 256; eb = t / 256; ecy = 0; eov = (t > 255);
         end
         12: begin
            ecy = 0;
            if (b == 0) eov = 1;
            else begin ea = a / b; eb = a % b; eov = 0; end
         end
         default: ;
      endcase
   endtask

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] pack_out();
      return {7'd0, out_valid, acc_out, b_out, 5'd0, cy_out, ac_out, ov_out};
   endfunction

   // called at a falling edge; drives one request and checks at the next falling edge
   task automatic run_op(input int op, input int a, input int o, input int b,
                         input int cy, input int ac, input int ov);
      int ea, eb, ecy, eac, eov;
      logic [31:0] expv;
      op_sel = 4'(op); acc_in = 8'(a); opnd_in = 8'(o); b_in = 8'(b);
      cy_in = 1'(cy); ac_in = 1'(ac); ov_in = 1'(ov); in_valid = 1'b1;
      model(op, a, o, b, cy, ac, ov, ea, eb, ecy, eac, eov);
      expv = {7'd0, 1'b1, 8'(ea), 8'(eb), 5'd0, 1'(ecy), 1'(eac), 1'(eov)};
      @(negedge clk);
      check(tag_of(op), $sformatf("op %0d a=%02h o=%02h b=%02h", op, a, o, b), pack_out(), expv);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] held;
      repeat (3) @(negedge clk);
      // R12: reset state
      check("R12", "reset outputs", pack_out(), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(0, 8'h7F, 8'h01, 8'h11, 1, 0, 0);   // R1 signed overflow, nibble carry
      run_op(0, 8'hF0, 8'h20, 8'h00, 0, 1, 1);   // R1 carry out only
      run_op(1, 8'h44, 8'hCA, 8'h00, 0, 0, 0);   // R2 low byte
      run_op(1, 8'h1E, 8'h56, 8'h00, 1, 0, 0);   // R2 high byte with carry
      run_op(2, 8'h00, 8'h01, 8'h00, 0, 0, 0);   // R3 borrow
      run_op(2, 8'h80, 8'h01, 8'h00, 0, 0, 0);   // R3 signed overflow
      run_op(2, 8'h50, 8'h20, 8'h00, 1, 0, 0);   // R3 borrow-in
      run_op(0, 8'h34, 8'h49, 8'h00, 0, 0, 0);   // R1 BCD operands
      run_op(3, 8'h7D, 8'h00, 8'h00, 0, 0, 0);   // R4 low fix
      run_op(3, 8'h9A, 8'h00, 8'h00, 0, 0, 0);   // R4 both fixes
      run_op(3, 8'h12, 8'h00, 8'h00, 1, 1, 0);   // R4 flags drive fixes
      run_op(4, 8'h81, 8'h00, 8'h00, 0, 0, 0);   // R5
      run_op(5, 8'h81, 8'h00, 8'h00, 0, 0, 0);   // R5
      run_op(6, 8'h81, 8'h00, 8'h00, 0, 0, 0);   // R5
      run_op(7, 8'h80, 8'h00, 8'h00, 1, 0, 0);   // R5
      run_op(8, 8'hA5, 8'h00, 8'h3C, 1, 1, 1);   // R6
      run_op(9, 8'hFF, 8'h00, 8'h00, 1, 1, 1);   // R7 wrap up
      run_op(10, 8'h00, 8'h00, 8'h00, 0, 1, 0);  // R7 wrap down
      run_op(11, 8'hFF, 8'h00, 8'hFF, 1, 0, 0);  // R8 large product
      run_op(11, 8'h10, 8'h00, 8'h0F, 1, 0, 1);  // R8 small product
      run_op(12, 8'hFB, 8'h00, 8'h12, 1, 0, 1);  // R9
      run_op(12, 8'h5A, 8'h00, 8'h00, 1, 1, 0);  // R9 divide by zero
      run_op(13, 8'h3C, 8'h77, 8'h99, 1, 0, 1);  // R10 reserved

      // R11: idle cycle holds results
      held = pack_out();
      op_sel = 4'd9; acc_in = 8'h00; b_in = 8'hEE; in_valid = 1'b0;
      @(negedge clk);
      check("R11", "idle hold", pack_out(), {7'd0, 1'b0, held[23:0]});

      for (int i = 0; i < 600; i++) begin
         run_op(int'($urandom % 16), int'($urandom % 256), int'($urandom % 256),
                int'($urandom % 256), int'($urandom % 2), int'($urandom % 2),
                int'($urandom % 2));
      end

      in_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule